// File: doc/BRIEF.md
# Watchdog Expiration Response Sequencer

This block sits behind a window watchdog and decides what happens each time the watchdog expires. Every accepted expiration drives a reset pulse on a pad whose active level and drive style are selectable. The pulse length depends on the policy, the shutdown delay select and how power sequencing is configured. Depending on the policy, the block also asks for a shutdown-then-startup sequence, or it latches a stop state with the converters held off. It does not sequence the converters itself.

Time is counted in ticks of `tick_i`. There are `TICKS_PER_MS` ticks per millisecond, default 2, so a 7.5 ms delay is exact. Expirations are counted and compared with a threshold picked by the policy code. After a restart the count returns to zero. A sticky flag records that a restart or a stop took place.

The controller has four states:
- `ST_IDLE`: waiting for an expiration.
- `ST_PULSE`: the reset pulse of an ordinary or restarting expiration.
- `ST_STOP_PULSE`: the reset pulse that leads into stop.
- `ST_STOPPED`: the latched stop state.

Its transitions are:
- IDLE→PULSE on an accepted expiration that does not stop.
- IDLE→STOP_PULSE on an accepted expiration that does stop.
- PULSE→IDLE on the last tick of the pulse.
- STOP_PULSE→STOPPED on the last tick of the pulse.
- STOP_PULSE/STOPPED→IDLE on release, which is a flag clear or the stop mode being cleared.
- Any state→IDLE on soft reset.

Top module: `wdx_resp`

## Requirements
- R1: An expiration strobe seen in `ST_IDLE` starts a reset pulse. Strobes that arrive during a pulse or in stop are ignored and leave the count unchanged.
- R2: Policy code 2'b00 never requests a restart, and each pulse lasts 10 ms.
- R3: Policy code 2'b01 requests a restart on the first expiration. The request is a one-cycle `restart_req_o` strobe, registered in the cycle after the accepted strobe.
- R4: A pulse that comes with a restart or a stop entry lasts 10 ms plus the maximum shutdown delay. That delay is 7.5 ms when `sd_delay_sel_i`=0 and 15 ms when it is 1.
- R5: Policy codes 2'b10 and 2'b11 request a restart on the 2nd and the 4th counted expiration. Earlier expirations give 10 ms pulses. The running count is shown on `exp_count_o`.
- R6: `restart_flag_o` is set by every restart request and every stop entry. It holds until `flag_clr_i` is high for a cycle, and it is 0 after reset.
- R7: With `stop_mode_i`=1 and sequencing active, the first expiration gives a 10 ms pulse with no restart. The second expiration gives a shutdown-length pulse, raises `stop_o` and sets the flag. After that pulse the reset output stays inactive.
- R8: Stop is left only by `rst_n` low, `soft_rst_i`, `flag_clr_i`, or `stop_mode_i` going low.
- R9: With `seq_pin_ctrl_i`=1 and `seq_en_pin_i`=0, no restart or stop happens, and each pulse lasts 31 ms.
- R10: With `seq_pin_ctrl_i`=0, no restart or stop happens, and each pulse lasts 11 ms.
- R11: The count is zero after reset and zero after each restart. It saturates at 2^CNT_W-1, and `cnt_clr_i` high for a cycle zeroes it.
- R12: The pad outputs follow the polarity and drive mode.
  - Push-pull (`rst_open_drain_i`=0): `wdrst_oe_o`=1, and `wdrst_level_o` equals the asserted state XNOR `rst_active_high_i`.
  - Open drain: `wdrst_level_o`=0, and `wdrst_oe_o` is 1 exactly when the pad must be low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset (external reset or power cycle) |
| soft_rst_i | input | 1 | Synchronous software reset |
| expire_i | input | 1 | Watchdog expiration strobe |
| tick_i | input | 1 | Time-base tick, TICKS_PER_MS per ms |
| policy_i | input | 2 | Restart policy code |
| stop_mode_i | input | 1 | Stop-on-second-expiration mode |
| sd_delay_sel_i | input | 1 | Maximum shutdown delay select |
| seq_pin_ctrl_i | input | 1 | Power sequencing is pin-controlled |
| seq_en_pin_i | input | 1 | Sequencing enable pin is active |
| rst_active_high_i | input | 1 | Reset pad is active high |
| rst_open_drain_i | input | 1 | Reset pad is open drain |
| flag_clr_i | input | 1 | Write-one clear of the restart flag |
| cnt_clr_i | input | 1 | Write-one clear of the expiration count |
| wdrst_level_o | output | 1 | Pad output level |
| wdrst_oe_o | output | 1 | Pad output enable |
| restart_req_o | output | 1 | Shutdown-then-startup request strobe |
| stop_o | output | 1 | Stop state, converters off |
| restart_flag_o | output | 1 | Sticky restart flag |
| exp_count_o | output | CNT_W | Expiration count |

## Verification
An accepted strobe changes the state, counter, flag and restart strobe at the very next clock edge. The bench samples all of them on the falling edge after the one where it raised `expire_i`. A pulse lasts as many ticks as the timer consumes while the pad is asserted. The bench counts its own tick signal on each falling edge where the pad is asserted, and compares that count with the length in ms × 2 until the pad releases. Clear and release controls act at the next edge, and their effects are read one falling edge later.

// File: rtl/wdx_pkg.sv
package wdx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PULSE,
        ST_STOP_PULSE,
        ST_STOPPED
    } wdx_state_e;

    typedef enum logic [1:0] {
        LK_BASE,
        LK_SHUT,
        LK_ENOFF,
        LK_NOSEQ
    } wdx_len_kind_e;

    // Expirations needed before a restart; zero means never
    function automatic logic [2:0] policy_threshold(input logic [1:0] pol);
        logic [2:0] thr;
        unique case (pol)
            2'b00: thr = 3'd0;
            2'b01: thr = 3'd1;
            2'b10: thr = 3'd2;
            2'b11: thr = 3'd4;
        endcase
        return thr;
    endfunction

endpackage

// File: rtl/wdx_len_calc.sv
module wdx_len_calc
    import wdx_pkg::*;
#(
    parameter int TICKS_PER_MS = 2,
    parameter int TMR_W        = 7
) (
    input  wdx_len_kind_e      kind_i,
    input  logic               sd_sel_i,
    output logic [TMR_W-1:0]   len_o
);
    localparam int BASE_T  = 10 * TICKS_PER_MS;
    localparam int SD_LO_T = (15 * TICKS_PER_MS) / 2;
    localparam int SD_HI_T = 15 * TICKS_PER_MS;
    localparam int ENOFF_T = 31 * TICKS_PER_MS;
    localparam int NOSEQ_T = 11 * TICKS_PER_MS;

    always_comb begin
        unique case (kind_i)
            LK_BASE:  len_o = TMR_W'(BASE_T);
            LK_SHUT:  len_o = sd_sel_i ? TMR_W'(BASE_T + SD_HI_T) : TMR_W'(BASE_T + SD_LO_T);
            LK_ENOFF: len_o = TMR_W'(ENOFF_T);
            LK_NOSEQ: len_o = TMR_W'(NOSEQ_T);
        endcase
    end
endmodule

// File: rtl/wdx_exp_counter.sv
module wdx_exp_counter #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             inc_i,
    output logic [CNT_W-1:0] count_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (inc_i && cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign count_o = cnt_q;

    AST_COUNT_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CNT_MAX && !clr_i) |=> cnt_q == CNT_MAX); // R11
    AST_COUNT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> cnt_q == '0); // R11
endmodule

// File: rtl/wdx_pulse_timer.sv
module wdx_pulse_timer #(
    parameter int TMR_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush_i,
    input  logic             load_i,
    input  logic [TMR_W-1:0] len_i,
    input  logic             tick_i,
    output logic             done_o
);
    logic [TMR_W-1:0] remain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain_q <= '0;
        end else if (flush_i) begin
            remain_q <= '0;
        end else if (load_i) begin
            remain_q <= len_i;
        end else if (tick_i && remain_q != '0) begin
            remain_q <= remain_q - 1'b1;
        end
    end

    assign done_o = tick_i && (remain_q == TMR_W'(1));

    AST_LOAD_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |-> len_i != '0); // R1
    AST_TMR_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (remain_q == '0 && !load_i) |=> remain_q == '0); // R1
endmodule

// File: rtl/wdx_pad.sv
module wdx_pad (
    input  logic asserted_i,
    input  logic act_high_i,
    input  logic open_drain_i,
    output logic level_o,
    output logic oe_o
);
    logic want_high;

    always_comb begin
        want_high = act_high_i ? asserted_i : !asserted_i;
        if (open_drain_i) begin
            level_o = 1'b0;
            oe_o    = !want_high;
        end else begin
            level_o = want_high;
            oe_o    = 1'b1;
        end
    end
endmodule

// File: rtl/wdx_resp.sv
module wdx_resp
    import wdx_pkg::*;
#(
    parameter int TICKS_PER_MS = 2,
    parameter int CNT_W        = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst_i,
    input  logic             expire_i,
    input  logic             tick_i,
    input  logic [1:0]       policy_i,
    input  logic             stop_mode_i,
    input  logic             sd_delay_sel_i,
    input  logic             seq_pin_ctrl_i,
    input  logic             seq_en_pin_i,
    input  logic             rst_active_high_i,
    input  logic             rst_open_drain_i,
    input  logic             flag_clr_i,
    input  logic             cnt_clr_i,
    output logic             wdrst_level_o,
    output logic             wdrst_oe_o,
    output logic             restart_req_o,
    output logic             stop_o,
    output logic             restart_flag_o,
    output logic [CNT_W-1:0] exp_count_o
);
    localparam int               MAX_LEN_T  = 31 * TICKS_PER_MS;
    localparam int               TMR_W      = $clog2(MAX_LEN_T + 1);
    localparam logic [CNT_W-1:0] CNT_MAX    = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] STOP_COUNT = CNT_W'(2);

    wdx_state_e       state_q, state_d;
    wdx_len_kind_e    kind;
    logic [TMR_W-1:0] pulse_len;
    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] count_after;
    logic [CNT_W-1:0] threshold;
    logic             seq_ok, go_stop, go_restart;
    logic             accept, release_stop, in_stop;
    logic             tmr_done, tmr_flush;
    logic             asserted;
    logic             flag_q, req_q;

    // Decision for the strobe currently presented
    always_comb begin
        count_after = (count == CNT_MAX) ? count : count + 1'b1;
        threshold   = CNT_W'(policy_threshold(policy_i));
        seq_ok      = seq_pin_ctrl_i && seq_en_pin_i;
        go_stop     = seq_ok && stop_mode_i && (count_after >= STOP_COUNT);
        go_restart  = seq_ok && !stop_mode_i && (threshold != '0)
                      && (count_after >= threshold);
        if (!seq_pin_ctrl_i)           kind = LK_NOSEQ;
        else if (!seq_en_pin_i)        kind = LK_ENOFF;
        else if (go_stop || go_restart) kind = LK_SHUT;
        else                           kind = LK_BASE;
    end

    assign accept       = (state_q == ST_IDLE) && expire_i && !soft_rst_i;
    assign in_stop      = (state_q == ST_STOP_PULSE) || (state_q == ST_STOPPED);
    assign release_stop = flag_clr_i || !stop_mode_i;
    assign tmr_flush    = soft_rst_i || (in_stop && release_stop);

    wdx_len_calc #(
        .TICKS_PER_MS (TICKS_PER_MS),
        .TMR_W        (TMR_W)
    ) u_len (
        .kind_i   (kind),
        .sd_sel_i (sd_delay_sel_i),
        .len_o    (pulse_len)
    );

    wdx_pulse_timer #(
        .TMR_W (TMR_W)
    ) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush_i (tmr_flush),
        .load_i  (accept),
        .len_i   (pulse_len),
        .tick_i  (tick_i),
        .done_o  (tmr_done)
    );

    wdx_exp_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (soft_rst_i || cnt_clr_i || (accept && go_restart)),
        .inc_i   (accept && !go_restart),
        .count_o (count)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          state_q <= ST_IDLE;
        else if (soft_rst_i) state_q <= ST_IDLE;
        else                 state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) state_d = go_stop ? ST_STOP_PULSE : ST_PULSE;
            end
            ST_PULSE: begin
                if (tmr_done) state_d = ST_IDLE;
            end
            ST_STOP_PULSE: begin
                if (release_stop)  state_d = ST_IDLE;
                else if (tmr_done) state_d = ST_STOPPED;
            end
            ST_STOPPED: begin
                if (release_stop) state_d = ST_IDLE;
            end
        endcase
    end

    // Registered request strobe and sticky flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q  <= 1'b0;
            flag_q <= 1'b0;
        end else if (soft_rst_i) begin
            req_q  <= 1'b0;
            flag_q <= 1'b0;
        end else begin
            req_q <= accept && go_restart;
            if (accept && (go_restart || go_stop)) flag_q <= 1'b1;
            else if (flag_clr_i)                   flag_q <= 1'b0;
        end
    end

    // Outputs
    always_comb begin
        asserted = 1'b0;
        stop_o   = 1'b0;
        unique case (state_q)
            ST_IDLE:       ;
            ST_PULSE:      asserted = 1'b1;
            ST_STOP_PULSE: begin asserted = 1'b1; stop_o = 1'b1; end
            ST_STOPPED:    stop_o = 1'b1;
        endcase
    end

    wdx_pad u_pad (
        .asserted_i   (asserted),
        .act_high_i   (rst_active_high_i),
        .open_drain_i (rst_open_drain_i),
        .level_o      (wdrst_level_o),
        .oe_o         (wdrst_oe_o)
    );

    assign restart_req_o  = req_q;
    assign restart_flag_o = flag_q;
    assign exp_count_o    = count;

    AST_RESTART_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        restart_req_o |=> !restart_req_o); // R3
    AST_RESTART_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        restart_req_o |-> restart_flag_o); // R6
    AST_RESTART_ZERO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        restart_req_o |-> exp_count_o == '0); // R11
    AST_STOP_ENTRY_PULSES: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stop_o) |-> (asserted && restart_flag_o)); // R7
    AST_RESTART_NEEDS_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
        restart_req_o |-> $past(seq_pin_ctrl_i && seq_en_pin_i)); // R9
    AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STOPPED && !soft_rst_i && !flag_clr_i && stop_mode_i)
        |=> state_q == ST_STOPPED); // R8
endmodule

// File: tb/wdx_resp_tb.sv
module wdx_resp_tb;
    localparam int TICK_DIV = 4;
    localparam int NVEC     = 12;

    typedef struct packed {
        logic [1:0] pol;
        logic       stp;
        logic       sd;
        logic       pc;
        logic       en;
        logic [3:0] n;
        logic [7:0] len;
        logic [3:0] rs;
        logic [2:0] cnt;
        logic       stop;
        logic       flag;
    } vec_t;

    // pol stp sd pc en n len(ticks) restarts cnt stop flag
    localparam vec_t VEC [NVEC] = '{
        '{2'b00, 1'b0, 1'b0, 1'b1, 1'b1, 4'd1, 8'd20, 4'd0, 3'd1, 1'b0, 1'b0}, // R2
        '{2'b01, 1'b0, 1'b0, 1'b1, 1'b1, 4'd1, 8'd35, 4'd1, 3'd0, 1'b0, 1'b1}, // R3 R4
        '{2'b01, 1'b0, 1'b1, 1'b1, 1'b1, 4'd1, 8'd50, 4'd1, 3'd0, 1'b0, 1'b1}, // R4
        '{2'b10, 1'b0, 1'b0, 1'b1, 1'b1, 4'd1, 8'd20, 4'd0, 3'd1, 1'b0, 1'b0}, // R5
        '{2'b10, 1'b0, 1'b0, 1'b1, 1'b1, 4'd2, 8'd35, 4'd1, 3'd0, 1'b0, 1'b1}, // R5
        '{2'b11, 1'b0, 1'b1, 1'b1, 1'b1, 4'd3, 8'd20, 4'd0, 3'd3, 1'b0, 1'b0}, // R5
        '{2'b11, 1'b0, 1'b1, 1'b1, 1'b1, 4'd4, 8'd50, 4'd1, 3'd0, 1'b0, 1'b1}, // R5
        '{2'b01, 1'b1, 1'b0, 1'b1, 1'b1, 4'd1, 8'd20, 4'd0, 3'd1, 1'b0, 1'b0}, // R7
        '{2'b01, 1'b1, 1'b0, 1'b1, 1'b1, 4'd2, 8'd35, 4'd0, 3'd2, 1'b1, 1'b1}, // R7
        '{2'b01, 1'b0, 1'b0, 1'b1, 1'b0, 4'd1, 8'd62, 4'd0, 3'd1, 1'b0, 1'b0}, // R9
        '{2'b01, 1'b0, 1'b1, 1'b0, 1'b1, 4'd1, 8'd22, 4'd0, 3'd1, 1'b0, 1'b0}, // R10
        '{2'b00, 1'b0, 1'b0, 1'b1, 1'b1, 4'd9, 8'd20, 4'd0, 3'd7, 1'b0, 1'b0}  // R11
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       soft_rst = 1'b0, expire = 1'b0, tick = 1'b0;
    logic [1:0] policy = 2'b00;
    logic       stop_mode = 1'b0, sd_sel = 1'b0, pin_ctrl = 1'b1, en_pin = 1'b1;
    logic       act_high = 1'b1, open_drain = 1'b0, flag_clr = 1'b0, cnt_clr = 1'b0;
    logic       level, oe, restart_req, stop, flag;
    logic [2:0] count;

    int tests = 0, fails = 0, cyc = 0, tdiv = 0;
    int m_len, m_rs;

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cyc  <= cyc + 1;
        tdiv <= (tdiv == TICK_DIV - 1) ? 0 : tdiv + 1;
        tick <= (tdiv == TICK_DIV - 1);
    end

    wdx_resp u_dut (
        .clk (clk), .rst_n (rst_n), .soft_rst_i (soft_rst), .expire_i (expire),
        .tick_i (tick), .policy_i (policy), .stop_mode_i (stop_mode),
        .sd_delay_sel_i (sd_sel), .seq_pin_ctrl_i (pin_ctrl), .seq_en_pin_i (en_pin),
        .rst_active_high_i (act_high), .rst_open_drain_i (open_drain),
        .flag_clr_i (flag_clr), .cnt_clr_i (cnt_clr),
        .wdrst_level_o (level), .wdrst_oe_o (oe), .restart_req_o (restart_req),
        .stop_o (stop), .restart_flag_o (flag), .exp_count_o (count)
    );

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Raise one expiration strobe, count ticks while the pad is asserted
    // (push-pull, active high), and count restart strobes
    task automatic fire(output int len, output int rs);
        len = 0;
        rs  = 0;
        @(negedge clk) expire = 1'b1;
        @(negedge clk) expire = 1'b0;
        if (restart_req) rs++;
        while (level && cyc < 150000) begin
            if (tick) len++;
            @(negedge clk);
        end
    endtask

    task automatic pulse_sig(input int which);
        @(negedge clk);
        case (which)
            0: soft_rst = 1'b1;
            1: flag_clr = 1'b1;
            default: cnt_clr = 1'b1;
        endcase
        @(negedge clk);
        soft_rst = 1'b0; flag_clr = 1'b0; cnt_clr = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state: R6 R11 R12
        check("R12 reset level", level, 0);
        check("R12 reset oe", oe, 1);
        check("R6 reset flag", flag, 0);
        check("R11 reset count", count, 0);
        check("R8 reset stop", stop, 0);

        // Vector table
        for (int i = 0; i < NVEC; i++) begin
            int rs_sum;
            pulse_sig(0);
            policy = VEC[i].pol; stop_mode = VEC[i].stp; sd_sel = VEC[i].sd;
            pin_ctrl = VEC[i].pc; en_pin = VEC[i].en;
            rs_sum = 0;
            for (int k = 0; k < int'(VEC[i].n); k++) begin
                fire(m_len, m_rs);
                rs_sum += m_rs;
            end
            check($sformatf("R1 R4 vec%0d pulse ticks", i), m_len, int'(VEC[i].len));
            check($sformatf("R3 R5 vec%0d restarts", i), rs_sum, int'(VEC[i].rs));
            check($sformatf("R5 R11 vec%0d count", i), count, int'(VEC[i].cnt));
            check($sformatf("R7 vec%0d stop", i), stop, int'(VEC[i].stop));
            check($sformatf("R6 vec%0d flag", i), flag, int'(VEC[i].flag));
        end

        // Stop state from last stop vector setup: ignore, release paths (R8, R7, R1)
        pulse_sig(0);
        policy = 2'b01; stop_mode = 1'b1; sd_sel = 1'b0; pin_ctrl = 1'b1; en_pin = 1'b1;
        fire(m_len, m_rs);
        fire(m_len, m_rs);
        check("R7 stop entered", stop, 1);
        check("R7 reset inactive in stop", level, 0);
        fire(m_len, m_rs);
        check("R1 expiry ignored in stop pulse", m_len, 0);
        check("R1 count unchanged in stop", count, 2);
        check("R8 still stopped", stop, 1);
        pulse_sig(1);
        check("R8 flag clear leaves stop", stop, 0);
        check("R6 flag cleared", flag, 0);
        pulse_sig(0);
        fire(m_len, m_rs);
        fire(m_len, m_rs);
        @(negedge clk) stop_mode = 1'b0;
        @(negedge clk);
        check("R8 mode clear leaves stop", stop, 0);
        stop_mode = 1'b1;
        pulse_sig(0);
        fire(m_len, m_rs);
        fire(m_len, m_rs);
        pulse_sig(0);
        check("R8 soft reset leaves stop", stop, 0);
        stop_mode = 1'b0;

        // Strobe during a pulse is ignored (R1), counter clear (R11)
        policy = 2'b00;
        @(negedge clk) expire = 1'b1;
        @(negedge clk) expire = 1'b0;
        repeat (10) @(negedge clk);
        expire = 1'b1;
        @(negedge clk) expire = 1'b0;
        while (level) @(negedge clk);
        check("R1 strobe during pulse ignored", count, 1);
        pulse_sig(2);
        check("R11 count clear", count, 0);

        // Pad modes (R12)
        act_high = 1'b0;
        @(negedge clk);
        check("R12 active-low idle level", level, 1);
        open_drain = 1'b1;
        @(negedge clk);
        check("R12 open-drain idle oe", oe, 0);
        check("R12 open-drain level", level, 0);
        @(negedge clk) expire = 1'b1;
        @(negedge clk) expire = 1'b0;
        check("R12 open-drain asserted oe", oe, 1);
        act_high = 1'b1;
        @(negedge clk);
        check("R12 open-drain active-high asserted oe", oe, 0);
        open_drain = 1'b0;
        @(negedge clk);
        check("R12 push-pull active-high asserted level", level, 1);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule